// File: doc/BRIEF.md
# Synchronous Burst Flash Clock and Latency Unit

This unit produces the clock for synchronous burst reads from a NOR flash device, deriving it from the system clock with a programmable divide ratio. It then waits a programmable number of memory clock periods before it reports that the first data word is ready. Both settings are captured when a burst is accepted. The memory clock runs only while a burst is open.

From the point where the first word is due, a one-system-clock sample strobe marks every rising edge of the memory clock. A datapath uses this strobe to capture read data. A sticky first-data flag stays high until the burst is closed. The divide and latency fields are ignored outside a burst. A cellular RAM device would be used with a latency field of zero, and both fields are normally fifteen after a register reset.

Top module: `sbf_clk_lat`

## Requirements
- R1: While no burst is open, including during and after reset, mem_clk_o, sample_o and first_valid_o are all low.
- R2: During a burst the memory clock period is div_i+1 system clocks, using the div_i value captured when the burst was accepted. A captured div_i of 0 is treated as 1, which gives a period of 2.
- R3: Each memory clock period starts with a high phase of floor((div_i+1)/2) system clocks and ends with a low phase that takes the remaining cycles. The first rising edge appears in the cycle right after burst_start_i is accepted.
- R4: Number the rising edges of the memory clock from 0, starting with the first. The first sample_o pulse occurs on rising edge number lat_i+2, where lat_i is the value captured at burst start.
- R5: After the first pulse, sample_o pulses on every later rising edge for exactly one system clock, in the same cycle that mem_clk_o goes high. It is low in all other cycles.
- R6: first_valid_o rises in the cycle of the first sample_o pulse and stays high until the burst ends.
- R7: When burst_end_i is sampled high during a burst, all three outputs are low from the next cycle and the burst is closed.
- R8: While a burst is open, a new burst_start_i and any change on div_i or lat_i have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| burst_start_i | input | 1 | Opens a burst when idle (one-cycle pulse) |
| burst_end_i | input | 1 | Closes an open burst |
| div_i | input | 4 | Divide field; period is value+1 system clocks |
| lat_i | input | 4 | Latency field; first data after value+2 memory clocks |
| mem_clk_o | output | 1 | Memory clock, low when idle |
| sample_o | output | 1 | One-cycle strobe at a data-carrying rising edge |
| first_valid_o | output | 1 | High from the first data edge until burst end |

## Verification
The assertions assume that reset is applied before any burst starts. They also assume that every burst is closed only through burst_end_i. Under those conditions the low phase of the memory clock is at least one cycle, so a strobe always follows a low cycle of the clock. The directed tasks open each burst from idle with a single-cycle start pulse and close it with a single-cycle end pulse. They change the fields and repeat the start pulse only inside an open burst, so the R8 case stays within these same conditions.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic {
    BST_IDLE = 1'b0,
    BST_RUN  = 1'b1
  } burst_st_e;

  localparam int unsigned SBF_LAT_OFS = 2;
endpackage

// File: rtl/sbf_burst_ctrl.sv
module sbf_burst_ctrl #(
  parameter int unsigned DIV_W = 4,
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_start_i,
  input  logic             burst_end_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             run_q_o,
  output logic             run_nxt_o,
  output logic             start_acc_o,
  output logic [DIV_W-1:0] div_eff_o,
  output logic [LAT_W-1:0] lat_eff_o
);
  import sbf_pkg::*;

  localparam logic [DIV_W-1:0] DIV_MIN = {{(DIV_W-1){1'b0}}, 1'b1};

  burst_st_e        st_q, st_nxt;
  logic [DIV_W-1:0] div_q, div_fix;
  logic [LAT_W-1:0] lat_q;
  logic             start_acc, end_acc, cfg_en;

  always_comb begin
    start_acc = burst_start_i && (st_q == BST_IDLE);
    end_acc   = burst_end_i && (st_q == BST_RUN);
    cfg_en    = start_acc;
    div_fix   = (div_i == '0) ? DIV_MIN : div_i;
    st_nxt    = st_q;
    if (start_acc)    st_nxt = BST_RUN;
    else if (end_acc) st_nxt = BST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= BST_IDLE;
    else         st_q <= st_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_MIN;
      lat_q <= '0;
    end else if (cfg_en) begin
      div_q <= div_fix;
      lat_q <= lat_i;
    end
  end

  assign run_q_o     = (st_q == BST_RUN);
  assign run_nxt_o   = (st_nxt == BST_RUN);
  assign start_acc_o = start_acc;
  assign div_eff_o   = start_acc ? div_fix : div_q;
  assign lat_eff_o   = start_acc ? lat_i : lat_q;
endmodule

// File: rtl/sbf_phase_gen.sv
module sbf_phase_gen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_nxt_i,
  input  logic             start_acc_i,
  input  logic [DIV_W-1:0] div_eff_i,
  output logic             mem_clk_o,
  output logic             rise_nxt_o
);
  logic [DIV_W-1:0] ph_q, ph_nxt;
  logic [DIV_W:0]   per_w;
  logic [DIV_W-1:0] high_len;
  logic             mclk_q, mclk_nxt;

  always_comb begin
    per_w    = {1'b0, div_eff_i} + {{DIV_W{1'b0}}, 1'b1};
    high_len = per_w[DIV_W:1];
    if (!run_nxt_i || start_acc_i)   ph_nxt = '0;
    else if (ph_q == div_eff_i)      ph_nxt = '0;
    else                             ph_nxt = ph_q + {{(DIV_W-1){1'b0}}, 1'b1};
    mclk_nxt   = run_nxt_i && (ph_nxt < high_len);
    rise_nxt_o = run_nxt_i && (ph_nxt == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      mclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_nxt;
      mclk_q <= mclk_nxt;
    end
  end

  assign mem_clk_o = mclk_q;
endmodule

// File: rtl/sbf_lat_count.sv
module sbf_lat_count #(
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_nxt_i,
  input  logic             start_acc_i,
  input  logic             rise_nxt_i,
  input  logic [LAT_W-1:0] lat_eff_i,
  output logic             sample_o,
  output logic             first_valid_o
);
  localparam int unsigned IDX_W = LAT_W + 1;
  localparam logic [IDX_W-1:0] OFS = IDX_W'(sbf_pkg::SBF_LAT_OFS);

  logic [IDX_W-1:0] idx_q, idx_nxt, tgt;
  logic             smp_q, smp_nxt, vld_q, vld_nxt;

  always_comb begin
    tgt = {1'b0, lat_eff_i} + OFS;
    if (start_acc_i)                    idx_nxt = '0;
    else if (rise_nxt_i && idx_q != tgt) idx_nxt = idx_q + {{(IDX_W-1){1'b0}}, 1'b1};
    else                                idx_nxt = idx_q;
    smp_nxt = rise_nxt_i && (idx_nxt == tgt);
    vld_nxt = run_nxt_i && (vld_q || smp_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      smp_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_nxt;
      smp_q <= smp_nxt;
      vld_q <= vld_nxt;
    end
  end

  assign sample_o      = smp_q;
  assign first_valid_o = vld_q;
endmodule

// File: rtl/sbf_clk_lat.sv
module sbf_clk_lat #(
  parameter int unsigned DIV_W = 4,
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_start_i,
  input  logic             burst_end_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             mem_clk_o,
  output logic             sample_o,
  output logic             first_valid_o
);
  logic             run_q, run_nxt, start_acc, rise_nxt;
  logic [DIV_W-1:0] div_eff;
  logic [LAT_W-1:0] lat_eff;

  sbf_burst_ctrl #(.DIV_W(DIV_W), .LAT_W(LAT_W)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .burst_start_i(burst_start_i), .burst_end_i(burst_end_i),
    .div_i(div_i), .lat_i(lat_i),
    .run_q_o(run_q), .run_nxt_o(run_nxt), .start_acc_o(start_acc),
    .div_eff_o(div_eff), .lat_eff_o(lat_eff)
  );

  sbf_phase_gen #(.DIV_W(DIV_W)) phase_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_nxt_i(run_nxt), .start_acc_i(start_acc), .div_eff_i(div_eff),
    .mem_clk_o(mem_clk_o), .rise_nxt_o(rise_nxt)
  );

  sbf_lat_count #(.LAT_W(LAT_W)) lat_i_u (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_nxt_i(run_nxt), .start_acc_i(start_acc), .rise_nxt_i(rise_nxt),
    .lat_eff_i(lat_eff),
    .sample_o(sample_o), .first_valid_o(first_valid_o)
  );
endmodule

// File: rtl/sbf_clk_lat_chk.sv
module sbf_clk_lat_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic burst_end_i,
  input logic mem_clk_o,
  input logic sample_o,
  input logic first_valid_o,
  input logic run_i
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!mem_clk_o && !sample_o && !first_valid_o));

  a_r5_strobe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $rose(mem_clk_o));

  a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  a_r6_valid_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(first_valid_o) |-> sample_o);

  a_r6_valid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_valid_o && !burst_end_i) |=> first_valid_o);

  a_r7_end_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && burst_end_i) |=> (!mem_clk_o && !first_valid_o && !sample_o));
endmodule

bind sbf_clk_lat sbf_clk_lat_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .burst_end_i(burst_end_i),
  .mem_clk_o(mem_clk_o), .sample_o(sample_o), .first_valid_o(first_valid_o),
  .run_i(run_q)
);

// File: tb/sbf_clk_lat_tb_top.sv
module sbf_clk_lat_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       burst_start_i = 1'b0;
  logic       burst_end_i = 1'b0;
  logic [3:0] div_i = 4'd15;
  logic [3:0] lat_i = 4'd15;
  logic       mem_clk_o, sample_o, first_valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  sbf_clk_lat dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .burst_start_i(burst_start_i), .burst_end_i(burst_end_i),
    .div_i(div_i), .lat_i(lat_i),
    .mem_clk_o(mem_clk_o), .sample_o(sample_o), .first_valid_o(first_valid_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b time=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "mem_clk_o idle", mem_clk_o, 1'b0);
    chk(req, "sample_o idle", sample_o, 1'b0);
    chk(req, "first_valid_o idle", first_valid_o, 1'b0);
  endtask

  // One burst; cycle t counts from the cycle after the start edge.
  task automatic run_burst(input logic [3:0] dv, input logic [3:0] lt, input int len,
                           input bit disturb);
    int per, hi;
    per = ((dv == 4'd0) ? 1 : int'(dv)) + 1;
    hi  = per / 2;
    @(negedge clk_i);
    div_i = dv; lat_i = lt; burst_start_i = 1'b1;
    @(negedge clk_i);
    burst_start_i = 1'b0;
    for (int t = 0; t <= len; t++) begin
      chk("R2 R3", "mem_clk_o", mem_clk_o, ((t % per) < hi));
      chk("R4 R5", "sample_o", sample_o, ((t % per) == 0) && ((t / per) >= int'(lt) + 2));
      chk("R6", "first_valid_o", first_valid_o, t >= (int'(lt) + 2) * per);
      if (disturb && t == 3) begin  // R8: fields change and a second start mid-burst
        div_i = ~dv; lat_i = ~lt; burst_start_i = 1'b1;
      end else begin
        burst_start_i = 1'b0;
      end
      if (t == len) burst_end_i = 1'b1;
      @(negedge clk_i);
    end
    burst_end_i = 1'b0;
    chk_idle("R7");
    @(negedge clk_i);
    chk_idle("R1");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_idle("R1");
    run_burst(4'd1, 4'd0, 20, 1'b0);    // fastest clock, minimum latency
    run_burst(4'd0, 4'd1, 20, 1'b0);    // reserved divide value acts as 1 (R2)
    run_burst(4'd4, 4'd2, 40, 1'b0);    // odd period 5: high 2, low 3 (R3)
    run_burst(4'd2, 4'd0, 30, 1'b1);    // R8 disturbance during a burst
    run_burst(4'd15, 4'd15, 300, 1'b0); // reset-value fields: /16, latency 17
    run_burst(4'd7, 4'd3, 10, 1'b0);    // end before first data (R7)
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule